// File: doc/BRIEF.md
# Timestamp Counter with Compare and Overrun Flags

This block keeps a 16-bit timestamp that advances by one on every clock. Two compare units watch the timestamp, and a status register records the compare hits and counter overruns. Hardware sets the status flags. Software clears a flag by writing a one to its bit. A per-bit mask turns the flags into one interrupt request.

When the counter overruns, or when compare unit 0 hits while its clear option is on, the counter does not return to zero. It reloads from a programmable offset register. Compare unit 1 has a second mode. In that mode it compares its register against an external cycle-count input added to the counter shifted right by four. This lets software time an event inside a longer schedule.

All settings are reached through a small register port. Writes are synchronous, reads are combinational, and a 3-bit address selects the register. Address 0 is compare 0, 1 is compare 1, 2 is the reload offset, 3 is control, 4 is status, 5 is the mask, and 6 is the counter, which is read-only.

Top module: `stamp_timer`

## Requirements
- R1: Reset holds the counter at 0x0000. After reset the counter goes up by one on each clock. Its value appears on `tstamp` and reads back at address 6.
- R2: A status flag is set in the cycle after a compare register matches the counter while that register is non-zero. Compare 0 sets bit 14. Compare 1 sets bit 15 when control bit 0 is 0.
- R3: A compare register that holds 0x0000 never sets its flag, even when the counter or the cycle-mode sum is zero.
- R4: When control bit 0 is 1, compare 1 is matched against (`cyc_cnt` + counter[15:4]) modulo 2^16 instead of the raw counter.
- R5: When the counter is 0xFFFF, its next value is the offset register (address 2), and status bit 13 is set.
- R6: When control bit 1 is 1, a compare-0 hit loads the offset into the counter on the next cycle. If compare 0 holds 0xFFFF, bit 13 is set together with bit 14.
- R7: Writing status (address 4) clears each flag whose data bit is 1 and leaves flags written with 0 unchanged. A hardware set in the same cycle as a clear wins.
- R8: Status resets to 0x0001. Bits 9, 8, 2 and 1 always read 0, and writes to them have no effect. Bits other than 15, 14, 13 and 0 read 0.
- R9: `irq` is high when some status bit is 1 and its mask bit (address 5) is 0. The mask resets to 0xFFFF.
- R10: Addresses 0, 1, 2, 3 and 5 read back what was last written to them (control keeps bits 1:0). A write to address 6 has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| cyc_cnt | input | 16 | External cycle count used by compare 1 in cycle mode |
| tstamp | output | 16 | Current counter value |
| irq | output | 1 | Interrupt request from unmasked flags |

## Verification
Compare 0 is first tried against a raw counter value reached from below. This separates a true equality match from a flag that is set too early or never. Compare 1 is then loaded with a value that only the cycle-mode sum reaches in the wait window. The flag therefore shows that the mode bit selects the sum rather than the raw count.

Long waits across the 0xFFFF boundary are run with an offset of zero and then with 0xFFF0. With offset zero, the zero-valued compare registers face a counter that really is zero, which tells the zero rule apart from a plain equality. With 0xFFF0, the reload value differs from a wrap to zero. Finally, clears are timed to land in the exact overrun cycle and in a quiet cycle, which tells set priority apart from clear priority.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  typedef enum logic [2:0] {
    A_CMP0 = 3'd0,
    A_CMP1 = 3'd1,
    A_OFFS = 3'd2,
    A_CTRL = 3'd3,
    A_STAT = 3'd4,
    A_MASK = 3'd5,
    A_CNT  = 3'd6
  } addr_e;

  localparam int unsigned FLG_HIT1 = 15;
  localparam int unsigned FLG_HIT0 = 14;
  localparam int unsigned FLG_OVR  = 13;
  localparam int unsigned FLG_INIT = 0;

  localparam int unsigned CTL_ALT = 0;
  localparam int unsigned CTL_CLR = 1;
  localparam int unsigned CTL_W   = 2;

  localparam int unsigned N_CMP   = 2;

  localparam logic [15:0] STAT_RST  = 16'h0001;
  localparam logic [15:0] STAT_LIVE = 16'hE001;
endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload_req,
  input  logic [W-1:0] offs,
  output logic [W-1:0] cnt,
  output logic         at_top
);
  logic [W-1:0] cnt_d;

  assign at_top = (cnt == {W{1'b1}});

  always_comb begin
    if (at_top || reload_req) cnt_d = offs;
    else                      cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/stamp_match.sv
module stamp_match #(
  parameter int unsigned W     = 16,
  parameter int unsigned SHIFT = 4,
  parameter bit          ALT   = 1'b0
) (
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cyc,
  input  logic         alt_sel,
  output logic         hit
);
  logic [W-1:0] ref_v;

  generate
    if (ALT) begin : g_alt
      always_comb begin
        if (alt_sel) ref_v = cyc + (cnt >> SHIFT);
        else         ref_v = cnt;
      end
    end else begin : g_raw
      logic unused_alt;
      assign unused_alt = ^{alt_sel, cyc};
      assign ref_v = cnt;
    end
  endgenerate

  assign hit = (cmp != '0) && (cmp == ref_v);
endmodule

// File: rtl/stamp_status.sv
module stamp_status #(
  parameter int unsigned W     = 16,
  parameter logic [W-1:0] RST_V = '0,
  parameter logic [W-1:0] LIVE  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic         clr_en,
  input  logic [W-1:0] clr_v,
  input  logic [W-1:0] mask,
  output logic [W-1:0] stat,
  output logic         irq
);
  logic [W-1:0] stat_d;
  logic [W-1:0] clr_eff;
  logic         upd;

  always_comb begin
    clr_eff = clr_en ? clr_v : '0;
    stat_d  = ((stat & ~clr_eff) | set_v) & LIVE;
    upd     = clr_en | (|set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat <= RST_V;
    else if (upd) stat <= stat_d;
  end

  assign irq = |(stat & ~mask);
endmodule

// File: rtl/stamp_timer.sv
module stamp_timer
  import stamp_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned SHIFT = 4
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] cyc_cnt,
  output logic [W-1:0] tstamp,
  output logic         irq
);
  localparam logic [W-1:0] ST_RST  = W'(STAT_RST);
  localparam logic [W-1:0] ST_LIVE = W'(STAT_LIVE);

  // reset: asserted at once, released after two edges
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  // configuration registers
  logic [W-1:0]     cmp_q [N_CMP];
  logic [W-1:0]     offs_q, mask_q;
  logic [CTL_W-1:0] ctrl_q;
  logic [N_CMP-1:0] cmp_we;
  logic             offs_we, ctrl_we, mask_we, stat_we;

  always_comb begin
    cmp_we[0] = reg_we && (reg_addr == A_CMP0);
    cmp_we[1] = reg_we && (reg_addr == A_CMP1);
    offs_we   = reg_we && (reg_addr == A_OFFS);
    ctrl_we   = reg_we && (reg_addr == A_CTRL);
    mask_we   = reg_we && (reg_addr == A_MASK);
    stat_we   = reg_we && (reg_addr == A_STAT);
  end

  generate
    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cmp_q[i] <= '0;
        else if (cmp_we[i]) cmp_q[i] <= reg_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_q <= '0;
      ctrl_q <= '0;
      mask_q <= '1;
    end else begin
      if (offs_we) offs_q <= reg_wdata;
      if (ctrl_we) ctrl_q <= reg_wdata[CTL_W-1:0];
      if (mask_we) mask_q <= reg_wdata;
    end
  end

  // counter and compare units
  logic [N_CMP-1:0] hit;
  logic             at_top;
  logic             clr_en;
  logic [W-1:0]     stat;

  assign clr_en = ctrl_q[CTL_CLR];

  stamp_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_req (clr_en && hit[0]),
    .offs       (offs_q),
    .cnt        (tstamp),
    .at_top     (at_top)
  );

  generate
    for (genvar i = 0; i < N_CMP; i++) begin : g_match
      stamp_match #(.W(W), .SHIFT(SHIFT), .ALT(i == 1)) u_match (
        .cmp     (cmp_q[i]),
        .cnt     (tstamp),
        .cyc     (cyc_cnt),
        .alt_sel (ctrl_q[CTL_ALT]),
        .hit     (hit[i])
      );
    end
  endgenerate

  // status flags
  logic [W-1:0] set_v;
  always_comb begin
    set_v           = '0;
    set_v[FLG_HIT1] = hit[1];
    set_v[FLG_HIT0] = hit[0];
    set_v[FLG_OVR]  = at_top;
  end

  stamp_status #(.W(W), .RST_V(ST_RST), .LIVE(ST_LIVE)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_v  (set_v),
    .clr_en (stat_we),
    .clr_v  (reg_wdata),
    .mask   (mask_q),
    .stat   (stat),
    .irq    (irq)
  );

  // read mux
  always_comb begin
    case (reg_addr)
      A_CMP0:  reg_rdata = cmp_q[0];
      A_CMP1:  reg_rdata = cmp_q[1];
      A_OFFS:  reg_rdata = offs_q;
      A_CTRL:  reg_rdata = W'(ctrl_q);
      A_STAT:  reg_rdata = stat;
      A_MASK:  reg_rdata = mask_q;
      A_CNT:   reg_rdata = tstamp;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/stamp_timer_chk.sv
module stamp_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] tstamp,
  input logic [W-1:0] offs,
  input logic [W-1:0] cmp0,
  input logic [W-1:0] stat,
  input logic [W-1:0] mask,
  input logic         irq,
  input logic         hit0,
  input logic         hit1,
  input logic         clr_en
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tstamp != {W{1'b1}} && !(clr_en && hit0)) |=> tstamp == $past(tstamp) + W'(1));

  a_r5_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tstamp == {W{1'b1}}) |=> (tstamp == $past(offs)) && stat[13]);

  a_r6_clear_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && hit0) |=> tstamp == $past(offs));

  a_r3_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmp0) == '0 && !$past(stat[14])) |-> !stat[14]);

  a_r7_set_wins0: assert property (@(posedge clk) disable iff (!rst_n)
    hit0 |=> stat[14]);

  a_r7_set_wins1: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> stat[15]);

  a_r8_ro_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[9:8] == 2'b00) && (stat[2:1] == 2'b00));

  a_r9_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat & ~mask));
endmodule

bind stamp_timer stamp_timer_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tstamp (tstamp),
  .offs   (offs_q),
  .cmp0   (cmp_q[0]),
  .stat   (stat),
  .mask   (mask_q),
  .irq    (irq),
  .hit0   (hit[0]),
  .hit1   (hit[1]),
  .clr_en (clr_en)
);

// File: tb/stamp_timer_test.sv
`timescale 1ns/1ps
module stamp_timer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [15:0] cyc_cnt = 16'h1000;
  logic [15:0] tstamp;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stamp_timer uut (
    .clk(clk), .rst_ni(rst_ni), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_cnt(cyc_cnt),
    .tstamp(tstamp), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 read-check, 2 wait, 3 irq-check
    logic [2:0]  addr;
    logic [15:0] val;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd3, 16'h0000, 8'd10},
    '{2'd0, 3'd4, 16'h0001, 8'd7},  // R7 clear reset flag
    '{2'd1, 3'd4, 16'h0000, 8'd7},
    '{2'd0, 3'd0, 16'h0400, 8'd10},
    '{2'd1, 3'd0, 16'h0400, 8'd10}, // R10 readback
    '{2'd2, 3'd0, 16'h0500, 8'd2},
    '{2'd1, 3'd4, 16'h4000, 8'd2},  // R2 raw compare 0
    '{2'd0, 3'd3, 16'h0001, 8'd4},
    '{2'd0, 3'd1, 16'h1080, 8'd4},
    '{2'd2, 3'd0, 16'h0400, 8'd4},
    '{2'd1, 3'd4, 16'hC000, 8'd4},  // R4 cycle-mode hit
    '{2'd0, 3'd4, 16'hC000, 8'd7},
    '{2'd1, 3'd4, 16'h0000, 8'd7},
    '{2'd0, 3'd1, 16'h0000, 8'd3},
    '{2'd0, 3'd3, 16'h0002, 8'd6},
    '{2'd1, 3'd3, 16'h0002, 8'd10},
    '{2'd0, 3'd2, 16'h0000, 8'd6},
    '{2'd0, 3'd0, 16'hFFFF, 8'd6},
    '{2'd0, 3'd5, 16'hBFFF, 8'd9},
    '{2'd3, 3'd0, 16'h0000, 8'd9},  // R9 nothing pending
    '{2'd2, 3'd0, 16'hF800, 8'd6},
    '{2'd1, 3'd4, 16'h6000, 8'd6},  // R6 and R3: no bit 15 at zero
    '{2'd3, 3'd0, 16'h0001, 8'd9},
    '{2'd0, 3'd5, 16'hFFFF, 8'd9},
    '{2'd3, 3'd0, 16'h0000, 8'd9},
    '{2'd0, 3'd3, 16'h0000, 8'd5},
    '{2'd0, 3'd0, 16'h0000, 8'd3},
    '{2'd0, 3'd2, 16'hFFF0, 8'd5},
    '{2'd0, 3'd4, 16'h6000, 8'd5},
    '{2'd2, 3'd0, 16'hFFFF, 8'd5}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic poll_cnt(input logic [15:0] v);
    logic [15:0] c;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      rd(3'd6, c);
      if (c == v) break;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d, c1, c2;
    // reset state
    repeat (3) @(negedge clk);
    chk("R1 counter in reset", tstamp, 16'h0000);
    rd(3'd4, d); chk("R8 status reset", d, 16'h0001);
    rd(3'd5, d); chk("R9 mask reset", d, 16'hFFFF);
    chk("R9 irq in reset", {15'h0, irq}, 16'h0000);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R8 read-only bits ignore writes, reset flag untouched
    wr(3'd4, 16'h0306);
    rd(3'd4, d); chk("R8 read-only bits", d, 16'h0001);
    // R10 write to counter address ignored
    wr(3'd6, 16'hF000);
    rd(3'd6, c1);
    chk("R10 counter write ignored", {15'h0, (c1 < 16'h0100)}, 16'h0001);
    @(negedge clk);
    rd(3'd6, c2);
    chk("R1 counter step", c2, c1 + 16'h1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        2'd0: wr(VEC[i].addr, VEC[i].val);
        2'd1: begin
          @(negedge clk);
          rd(VEC[i].addr, d);
          chk($sformatf("R%0d vector %0d", VEC[i].req, i), d, VEC[i].val);
        end
        2'd2: repeat (int'(VEC[i].val)) @(negedge clk);
        default: begin
          @(negedge clk);
          chk($sformatf("R%0d irq vector %0d", VEC[i].req, i), {15'h0, irq}, VEC[i].val);
        end
      endcase
    end
    @(negedge clk);
    rd(3'd4, d); chk("R5 overrun only", d, 16'h2000);

    // R5 reload to offset: counter cycles within FFF0..FFFF
    @(negedge clk);
    rd(3'd6, c1);
    @(negedge clk);
    rd(3'd6, c2);
    chk("R5 counter in reload range", {15'h0, (c1 >= 16'hFFF0)}, 16'h0001);
    chk("R5 reload step", c2, (c1 == 16'hFFFF) ? 16'hFFF0 : c1 + 16'h1);

    // R7 set wins over a clear in the same cycle
    wr(3'd0, 16'hFFFF);
    poll_cnt(16'hFFFF);
    reg_addr = 3'd4; reg_wdata = 16'h6000; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    rd(3'd4, d); chk("R7 set beats clear", d, 16'h6000);
    // R7 clear in a quiet cycle
    poll_cnt(16'hFFF5);
    reg_addr = 3'd4; reg_wdata = 16'h6000; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    rd(3'd4, d); chk("R7 quiet clear", d, 16'h0000);
    // R9 unmask overrun, irq follows the next overrun
    reg_addr = 3'd5; reg_wdata = 16'hDFFF; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R9 irq before overrun", {15'h0, irq}, 16'h0000);
    repeat (12) @(negedge clk);
    chk("R9 irq after overrun", {15'h0, irq}, 16'h0001);

    finish_run();
  end
endmodule